// File: doc/BRIEF.md
# Multi-Converter ADC Scan Sequencer

This block runs a continuous conversion scan over several identical multiplexed serial ADCs, five converters of eight inputs each by default. It drives all converters as parallel lanes on one shared serial clock and frame strobe, so each frame converts one input on every converter. A scan is eight frames, one for each mux position. Every input channel has its own gain and filter code. At the start of each frame the sequencer builds that channel's control word and shifts it out ahead of the conversion. The 12-bit result is then shifted back in, MSB first.

A host reaches the block through a simple 16-bit address and data bus. Each channel owns two consecutive words at the bus: a read-only result word and a read/write configuration word. A result word changes in one step when its frame ends, so the host never sees a partly assembled value. A status output flips each time a full scan completes. The host can poll it to find out when a fresh set of results exists.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset every result word and every configuration word reads 0x0000, the frame strobe and serial clock are low, and the scan flag is 0.
- R2: During a frame the strobe stays high for exactly 20 rising serial-clock edges. Each clock phase lasts DIV system cycles. The serial clock stays low while the strobe is low. The strobe is low for GAP cycles between frames.
- R3: A frame first sends an 8-bit control word on the serial data output, MSB first, as {mux[2:0], gain[2:0], filter[1:0]}. Each bit is stable across its rising clock edge and changes only after a falling edge.
- R4: The serial input is sampled on rising edges 9 to 20, which give the 12-bit result MSB first.
- R5: Frame k of a scan uses mux position k (0 to 7) on every lane, then the scan wraps to 0. Channel number = lane*8 + mux.
- R6: Channel c has its result word at 0xC10+2c and its configuration word at 0xC11+2c. The result word is {valid in bit 15, zeros, result in bits 11:0}. The configuration word holds gain in bits 2:0 and filter in bits 4:3, with all other bits 0.
- R7: A write to a configuration word stores bits 4:0 only. Writes to result words or to addresses outside 0xC10 to 0xC5F have no effect, and reads outside that range return 0.
- R8: A result word changes only at the clock edge where the frame strobe falls.
- R9: The configuration is captured when a frame starts. A write made during that channel's frame takes effect from the channel's next conversion.
- R10: The scan flag toggles at the end of the frame for mux position 7, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Host word address |
| bus_wdata_i | input | 16 | Host write data |
| bus_we_i | input | 1 | Host write strobe, sampled on the clock edge |
| bus_rdata_o | output | 16 | Host read data for bus_addr_i, combinational |
| adc_sclk_o | output | N_CONV | Serial clock, one per converter |
| adc_sdo_o | output | N_CONV | Control word bits to each converter |
| adc_sdi_i | input | N_CONV | Result bits from each converter |
| adc_cnv_o | output | N_CONV | Frame/convert strobe, active high |
| scan_flip_o | output | 1 | Toggles once per completed scan |

## Verification
Read data follows the address in the same cycle. A configuration write is visible from the cycle after its strobe edge. A result appears at the edge where the strobe falls, GAP + 40*DIV cycles after the frame began. The bench therefore does not count absolute cycles. It waits on strobe and scan-flag events, lets one falling system-clock edge pass to clear any same-edge race, and then samples. The converter model in the bench echoes the received control word and lane number inside its result, so each result read confirms the mux, gain and filter bits that reached the wire.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
package adc_scan_pkg;
  localparam int GAIN_W = 3;
  localparam int FILT_W = 2;
  localparam int CFG_W  = GAIN_W + FILT_W;

  // bit order matches the host config word: filt in [4:3], gain in [2:0]
  typedef struct packed {
    logic [FILT_W-1:0] filt;
    logic [GAIN_W-1:0] gain;
  } chan_cfg_t;
endpackage

// File: rtl/adc_scan_timer.sv
`timescale 1ns/1ps
module adc_scan_timer #(
  parameter int DIV        = 2,
  parameter int GAP        = 4,
  parameter int FRAME_BITS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic cnv_o,
  output logic sclk_o,
  output logic load_o,
  output logic rise_o,
  output logic fall_o,
  output logic done_o
);
  localparam int CMAX = (DIV > GAP) ? DIV : GAP;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int BW   = $clog2(FRAME_BITS);

  typedef enum logic {ST_GAP, ST_XFER} st_e;

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic          sclk_q;
  logic          gap_end, div_end, last_bit;

  assign gap_end  = (st_q == ST_GAP)  && (cnt_q == CW'(GAP - 1));
  assign div_end  = (st_q == ST_XFER) && (cnt_q == CW'(DIV - 1));
  assign last_bit = (bit_q == BW'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_GAP;
      cnt_q  <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      case (st_q)
        ST_GAP: begin
          if (gap_end) begin
            st_q  <= ST_XFER;
            cnt_q <= '0;
            bit_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (div_end) begin
            cnt_q <= '0;
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (last_bit) st_q <= ST_GAP;
              else          bit_q <= bit_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign cnv_o  = (st_q == ST_XFER);
  assign sclk_o = sclk_q;
  assign load_o = gap_end;
  assign rise_o = div_end && !sclk_q;
  assign fall_o = div_end && sclk_q && !last_bit;
  assign done_o = div_end && sclk_q && last_bit;
endmodule

// File: rtl/adc_scan_lane.sv
`timescale 1ns/1ps
module adc_scan_lane #(
  parameter int CTRL_W = 8,
  parameter int RES_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [RES_W-1:0]  rx_o
);
  logic [CTRL_W-1:0] tx_q;
  logic [RES_W-1:0]  rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)      tx_q <= ctrl_i;
      else if (fall_i) tx_q <= {tx_q[CTRL_W-2:0], 1'b0};
      // only the last RES_W samples of a frame survive
      if (rise_i)      rx_q <= {rx_q[RES_W-2:0], sdi_i};
    end
  end

  assign sdo_o = tx_q[CTRL_W-1];
  assign rx_o  = rx_q;
endmodule

// File: rtl/adc_scan_regs.sv
`timescale 1ns/1ps
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int          N_CONV    = 5,
  parameter int          N_CH      = 8,
  parameter int          RES_W     = 12,
  parameter logic [15:0] BASE_ADDR = 16'hC10,
  localparam int         MUX_W     = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      addr_i,
  input  logic [15:0]      wdata_i,
  input  logic             we_i,
  output logic [15:0]      rdata_o,
  input  logic             commit_i,
  input  logic [MUX_W-1:0] mux_i,
  input  logic [RES_W-1:0] rx_i  [N_CONV],
  output chan_cfg_t        cfg_o [N_CONV]
);
  localparam int N_TOT = N_CONV * N_CH;
  localparam int CH_W  = $clog2(N_TOT);

  logic [15:0]     off;
  logic            hit;
  logic [CH_W-1:0] ch;
  chan_cfg_t       cfg_a [N_TOT];
  logic [RES_W-1:0] res_a [N_TOT];
  logic            vld_a [N_TOT];

  assign off = addr_i - BASE_ADDR;
  assign hit = off < 16'(2 * N_TOT);
  assign ch  = off[CH_W:1];

  wire unused_wdata = ^wdata_i[15:CFG_W];

  for (genvar i = 0; i < N_TOT; i++) begin : g_ch
    localparam int         LANE = i / N_CH;
    localparam int         MPOS = i % N_CH;
    chan_cfg_t        cfg_q;
    logic [RES_W-1:0] res_q;
    logic             vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
        res_q <= '0;
        vld_q <= 1'b0;
      end else begin
        if (we_i && hit && off[0] && (ch == CH_W'(i)))
          cfg_q <= chan_cfg_t'(wdata_i[CFG_W-1:0]);
        if (commit_i && (mux_i == MUX_W'(MPOS))) begin
          res_q <= rx_i[LANE];
          vld_q <= 1'b1;
        end
      end
    end

    assign cfg_a[i] = cfg_q;
    assign res_a[i] = res_q;
    assign vld_a[i] = vld_q;
  end

  for (genvar l = 0; l < N_CONV; l++) begin : g_sel
    logic [CH_W-1:0] idx;
    assign idx      = CH_W'(l * N_CH) + CH_W'(mux_i);
    assign cfg_o[l] = cfg_a[idx];
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      if (off[0]) rdata_o = 16'(cfg_a[ch]);
      else        rdata_o = {vld_a[ch], {(15-RES_W){1'b0}}, res_a[ch]};
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int          N_CONV    = 5,
  parameter int          N_CH      = 8,
  parameter int          RES_W     = 12,
  parameter int          DIV       = 2,
  parameter int          GAP       = 4,
  parameter logic [15:0] BASE_ADDR = 16'hC10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       bus_addr_i,
  input  logic [15:0]       bus_wdata_i,
  input  logic              bus_we_i,
  output logic [15:0]       bus_rdata_o,
  output logic [N_CONV-1:0] adc_sclk_o,
  output logic [N_CONV-1:0] adc_sdo_o,
  input  logic [N_CONV-1:0] adc_sdi_i,
  output logic [N_CONV-1:0] adc_cnv_o,
  output logic              scan_flip_o
);
  localparam int MUX_W      = $clog2(N_CH);
  localparam int CTRL_W     = MUX_W + CFG_W;
  localparam int FRAME_BITS = CTRL_W + RES_W;

  logic             cnv, sclk, load, rise, fall, frame_done;
  logic [MUX_W-1:0] mux_q;
  logic             flip_q;
  logic [RES_W-1:0] lane_rx  [N_CONV];
  chan_cfg_t        lane_cfg [N_CONV];

  adc_scan_timer #(
    .DIV(DIV), .GAP(GAP), .FRAME_BITS(FRAME_BITS)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cnv_o(cnv), .sclk_o(sclk), .load_o(load),
    .rise_o(rise), .fall_o(fall), .done_o(frame_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mux_q  <= '0;
      flip_q <= 1'b0;
    end else if (frame_done) begin
      if (mux_q == MUX_W'(N_CH - 1)) begin
        mux_q  <= '0;
        flip_q <= ~flip_q;
      end else begin
        mux_q <= mux_q + 1'b1;
      end
    end
  end

  adc_scan_regs #(
    .N_CONV(N_CONV), .N_CH(N_CH), .RES_W(RES_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .we_i(bus_we_i),
    .rdata_o(bus_rdata_o),
    .commit_i(frame_done), .mux_i(mux_q),
    .rx_i(lane_rx), .cfg_o(lane_cfg)
  );

  for (genvar l = 0; l < N_CONV; l++) begin : g_lane
    logic [CTRL_W-1:0] ctrl;
    assign ctrl = {mux_q, lane_cfg[l].gain, lane_cfg[l].filt};

    adc_scan_lane #(.CTRL_W(CTRL_W), .RES_W(RES_W)) u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .load_i(load), .rise_i(rise), .fall_i(fall),
      .ctrl_i(ctrl), .sdi_i(adc_sdi_i[l]),
      .sdo_o(adc_sdo_o[l]), .rx_o(lane_rx[l])
    );
  end

  assign adc_sclk_o  = {N_CONV{sclk}};
  assign adc_cnv_o   = {N_CONV{cnv}};
  assign scan_flip_o = flip_q;
endmodule

// File: rtl/adc_scan_seq_chk.sv
`timescale 1ns/1ps
module adc_scan_seq_chk #(
  parameter int N_CONV     = 5,
  parameter int FRAME_BITS = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       bus_addr_i,
  input logic [15:0]       bus_rdata_o,
  input logic [N_CONV-1:0] adc_sclk_o,
  input logic [N_CONV-1:0] adc_sdo_o,
  input logic [N_CONV-1:0] adc_cnv_o,
  input logic              scan_flip_o,
  input logic              commit_i
);
  logic       sclk_d;
  logic [7:0] rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= adc_sclk_o[0];
      if (!adc_cnv_o[0])                          rise_cnt <= '0;
      else if (adc_sclk_o[0] && !sclk_d)          rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_cnv_o[0] |-> !adc_sclk_o[0]);

  // R2
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_cnv_o[0]) |-> (rise_cnt == 8'(FRAME_BITS)));

  // R3
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_sclk_o[0] && $past(adc_sclk_o[0])) |-> $stable(adc_sdo_o));

  // R8
  res_atomic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(commit_i) && $stable(bus_addr_i) && !bus_addr_i[0]) |-> $stable(bus_rdata_o));

  // R10
  flip_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scan_flip_o) |-> $past(commit_i));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(
  .N_CONV(N_CONV), .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o),
  .adc_sclk_o(adc_sclk_o), .adc_sdo_o(adc_sdo_o), .adc_cnv_o(adc_cnv_o),
  .scan_flip_o(scan_flip_o), .commit_i(frame_done)
);

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;
  localparam int N  = 5;
  localparam int NV = 8;
  localparam int DIV = 2;
  localparam int GAP = 4;
  // {channel[5:0], gain[2:0], filter[1:0]}
  localparam logic [10:0] VEC [NV] = '{
    {6'd0,  3'd5, 2'd2}, {6'd7,  3'd7, 2'd3}, {6'd8,  3'd1, 2'd0},
    {6'd15, 3'd2, 2'd1}, {6'd21, 3'd6, 2'd3}, {6'd30, 3'd3, 2'd2},
    {6'd33, 3'd4, 2'd1}, {6'd39, 3'd7, 2'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic we = 1'b0;
  logic [15:0] rdata;
  logic [N-1:0] sclk, sdo, sdi, cnv;
  logic flip;

  int checks = 0, fails = 0;
  int frame_n = 0, mux_err = 0, rise_err = 0;
  int rcnt [N];
  logic [7:0]  rctrl [N];
  logic [7:0]  last_ctrl [N];
  logic [11:0] rres [N];
  logic        sdi_l [N];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_scan_seq #(.N_CONV(N), .DIV(DIV), .GAP(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we), .bus_rdata_o(rdata),
    .adc_sclk_o(sclk), .adc_sdo_o(sdo), .adc_sdi_i(sdi), .adc_cnv_o(cnv),
    .scan_flip_o(flip)
  );

  always @(posedge cnv[0]) frame_n++;

  always_comb for (int l = 0; l < N; l++) sdi[l] = sdi_l[l];

  // converter model: result echoes {1, lane, received control word}
  for (genvar l = 0; l < N; l++) begin : g_adc
    initial begin rcnt[l] = 0; sdi_l[l] = 1'b0; rctrl[l] = '0; last_ctrl[l] = '0; end
    always @(posedge cnv[l]) rcnt[l] = 0;
    always @(posedge sclk[l]) begin
      if (rcnt[l] < 8) rctrl[l] = {rctrl[l][6:0], sdo[l]};
      rcnt[l] = rcnt[l] + 1;
    end
    always @(negedge sclk[l]) begin
      if (rcnt[l] == 8) begin
        rres[l] = {1'b1, 3'(l), rctrl[l]};
        last_ctrl[l] = rctrl[l];
        if (int'(rctrl[l][7:5]) != (frame_n - 1) % 8) mux_err++;
      end
      if (rcnt[l] >= 8 && rcnt[l] < 20) sdi_l[l] = rres[l][19 - rcnt[l]];
    end
    always @(negedge cnv[l]) if (rcnt[l] != 20) rise_err++;
  end

  function automatic logic [15:0] exp_res(int ch, int g, int f);
    return 16'h8800 | 16'((ch / 8) << 8) | 16'((ch % 8) << 5) | 16'(g << 2) | 16'(f);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic wait_mux_frame(int m);
    do begin
      @(posedge cnv[0]); @(negedge clk);
    end while ((frame_n - 1) % 8 != m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [15:0] d, d2;
    logic f0;
    realtime t0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cnv", 16'(cnv), 16'h0);
    check("R1 sclk", 16'(sclk), 16'h0);
    check("R1 flip", 16'(flip), 16'h0);
    rst_n = 1'b1;
    rd(16'hC10, d); check("R1 result ch0", d, 16'h0000);
    rd(16'hC11, d); check("R1 cfg ch0", d, 16'h0000);
    rd(16'hC5E, d); check("R1 result ch39", d, 16'h0000);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++)
      wr(16'hC11 + 16'(2 * int'(VEC[i][10:5])), 16'({VEC[i][1:0], VEC[i][4:2]}));
    f0 = flip; @(flip); @(flip);
    for (int i = 0; i < NV; i++) begin
      int ch = int'(VEC[i][10:5]);
      int g  = int'(VEC[i][4:2]);
      int f  = int'(VEC[i][1:0]);
      rd(16'hC11 + 16'(2 * ch), d);
      check("R6 cfg word", d, 16'(f << 3 | g));
      rd(16'hC10 + 16'(2 * ch), d);
      check("R3 R4 R5 result word", d, exp_res(ch, g, f));
    end
    rd(16'hC10 + 16'(2 * 12), d);
    check("R5 untouched ch12", d, exp_res(12, 0, 0));
    check("R5 mux order errors", 16'(mux_err), 16'h0);
    check("R2 rises per frame errors", 16'(rise_err), 16'h0);

    // R2 phase and gap lengths
    @(posedge sclk[0]); t0 = $realtime; @(negedge sclk[0]);
    check("R2 sclk high ns", 16'(int'($realtime - t0)), 16'(8 * DIV));
    @(negedge cnv[0]); t0 = $realtime; @(posedge cnv[0]);
    check("R2 gap ns", 16'(int'($realtime - t0)), 16'(8 * GAP));

    // R7 ignored writes and masking
    wr(16'hC16, 16'h1234);
    rd(16'hC16, d); check("R7 result write ignored", d, exp_res(3, 0, 0));
    wr(16'hC60, 16'h001F);
    rd(16'hC60, d); check("R7 read above range", d, 16'h0000);
    rd(16'hC0F, d); check("R7 read below range", d, 16'h0000);
    rd(16'hC11, d); check("R7 no alias ch0", d, 16'h0015);
    wr(16'hC17, 16'hFFFF);
    rd(16'hC17, d); check("R7 cfg mask", d, 16'h001F);

    // R9 write during the frame of ch1
    wait_mux_frame(1);
    wr(16'hC13, 16'h000B);
    @(negedge cnv[0]); @(negedge clk);
    check("R9 ctrl sent in frame", 16'(last_ctrl[0]), 16'h0020);
    rd(16'hC12, d); check("R9 result uses old cfg", d, exp_res(1, 0, 0));

    // R8 next ch1 frame: old value held until strobe falls
    wait_mux_frame(1);
    d2 = exp_res(1, 0, 0);
    forever begin
      rd(16'hC12, d);
      if (!cnv[0]) break;
      if (d !== d2) break;
    end
    check("R8 change only at strobe fall", 16'(cnv[0]), 16'h0);
    check("R9 R8 new result", d, exp_res(1, 3, 1));

    // R10 flip timing
    f0 = flip;
    @(flip); @(negedge clk);
    check("R10 flip toggled", 16'(flip), 16'(!f0));
    check("R10 at mux7 frame end", 16'((frame_n - 1) % 8), 16'd7);
    check("R10 strobe low", 16'(cnv[0]), 16'h0);

    finish_up();
  end
endmodule